// File: doc/BRIEF.md
# Banked Level-Sensitive Interrupt Controller with Shortcut Bits

This block collects 72 level-sensitive interrupt sources into three banks: a base bank of 8 local sources and two peripheral banks of 32 sources each. Each bank has its own enable mask, which software changes through a set port and a clear port. Both ports act per bit. A masked view of each bank can be read back as its pending word.

The base pending word is the one a handler reads first. Its low byte holds the enabled local sources. Two summary bits each stand for "some enabled, non-shortcut source in a peripheral bank is active". A group of shortcut bits copies eleven chosen peripheral sources directly, so a handler can find them without a second read. The summary bits and the shortcut bits can only be masked through the peripheral banks' own enables. The IRQ output is asserted whenever any bit of the base pending word is set.

A separate control register picks one of the 72 raw sources and routes it to the FIQ output. This path ignores the IRQ enables. If the chosen source is also enabled for IRQ, both outputs assert at the same time. The register bus is word-wide. Read data is registered, and so are both interrupt outputs.

Top module: `banked_irq_ctrl`

## Requirements
- R1: After synchronous reset, all three enable masks are zero, the FIQ control register is zero, and `irq_o`, `fiq_o` and `bus_rdata` are all zero.
- R2: The byte offsets are as follows. The set ports are at 0x10 (bank 1), 0x14 (bank 2) and 0x18 (bank 0). The clear ports are at 0x1C (bank 1), 0x20 (bank 2) and 0x24 (bank 0). Writing 1 to a bit enables (set port) or disables (clear port) that source, and writing 0 to a bit leaves it unchanged. Reading either port of a bank returns that bank's current enable mask.
- R3: The bank pending words are at 0x04 (bank 1) and 0x08 (bank 2). Each reads as the raw source levels ANDed with the bank's enable mask. Writes to the pending offsets have no effect. Read data appears on `bus_rdata` on the clock edge after the address is presented. An address whose two low bits are not zero, or which is not in the map, reads as zero and writes nothing.
- R4: Base pending word (offset 0x00) bits 7:0 are the bank-0 sources ANDed with the bank-0 enable mask.
- R5: Base bit 8 is set when any enabled bank-1 source that has no shortcut is active. Base bit 9 does the same for bank 2.
- R6: Base bits 10..14 copy the enabled bank-1 sources 7, 9, 10, 18 and 19, in that order. Base bits 15..20 copy the enabled bank-2 sources 21, 22, 23, 24, 25 and 30, in that order. A shortcut source sets its shortcut bit and its own bank pending bit, but not its bank's summary bit.
- R7: Bits 31:8 written to the bank-0 set or clear port have no effect. Bank-0 enable reads and base pending bits 31:21 are always zero.
- R8: `irq_o` equals the OR of all bits of the base pending word, delayed by one clock.
- R9: The FIQ control register is at offset 0x0C. Bits 6:0 hold the source index: 0–31 select bank 1, 32–63 select bank 2, and 64–71 select bank 0 sources 0–7. Bit 7 enables FIQ. Reading returns bits 7:0, and bits 31:8 read as zero.
- R10: `fiq_o` is the selected raw source ANDed with FIQ enable, delayed by one clock, regardless of the IRQ enables. Indices 72–127 select nothing. A source routed to FIQ and enabled for IRQ drives both outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_b0 | input | 8 | Bank-0 source levels |
| src_b1 | input | 32 | Bank-1 source levels |
| src_b2 | input | 32 | Bank-2 source levels |
| bus_addr | input | 8 | Byte address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_o | output | 1 | Registered IRQ request |
| fiq_o | output | 1 | Registered FIQ request |

## Verification
The bench targets the shortcut positions with every source of a bank held high. A design with a wrong shortcut table, or one that lets a shortcut source also raise the summary bit, shows a wrong base word such as 0x500 with an extra or missing bit. It writes all ones above bit 7 of the bank-0 enable ports and zeros to pending offsets; a design that decodes too many bits would show stray enable bits or an altered pending word. It routes FIQ to sources whose IRQ enable is clear, to a bank-0 index and to an index past 71. A design that gates FIQ by the IRQ enable, or wraps large indices, would drive `fiq_o` wrongly. A long random phase compares every output against a behavioural model on every cycle.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int B0_W    = 8;
  localparam int BK_W    = 32;
  localparam int N_SC1   = 5;
  localparam int N_SC2   = 6;
  localparam int SUM1_B  = 8;
  localparam int SUM2_B  = 9;
  localparam int SC_BASE = 10;
  localparam int BASE_W  = SC_BASE + N_SC1 + N_SC2;
  localparam int RAW_N   = B0_W + 2 * BK_W;
  localparam int IDX_W   = 7;

  // word indices (byte offset / 4)
  localparam int W_PEND0 = 0;
  localparam int W_PEND1 = 1;
  localparam int W_PEND2 = 2;
  localparam int W_FIQ   = 3;
  localparam int W_SET1  = 4;
  localparam int W_SET2  = 5;
  localparam int W_SET0  = 6;
  localparam int W_CLR1  = 7;
  localparam int W_CLR2  = 8;
  localparam int W_CLR0  = 9;

  function automatic int sc1_src(input int i);
    case (i)
      0: return 7;
      1: return 9;
      2: return 10;
      3: return 18;
      default: return 19;
    endcase
  endfunction

  function automatic int sc2_src(input int i);
    case (i)
      0: return 21;
      1: return 22;
      2: return 23;
      3: return 24;
      4: return 25;
      default: return 30;
    endcase
  endfunction

  function automatic logic [BK_W-1:0] sc1_mask();
    logic [BK_W-1:0] m;
    m = '0;
    for (int i = 0; i < N_SC1; i++) m[sc1_src(i)] = 1'b1;
    return m;
  endfunction

  function automatic logic [BK_W-1:0] sc2_mask();
    logic [BK_W-1:0] m;
    m = '0;
    for (int i = 0; i < N_SC2; i++) m[sc2_src(i)] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/irq_en_bank.sv
module irq_en_bank #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         set_we,
  input  logic         clr_we,
  input  logic [W-1:0] wbits,
  input  logic [W-1:0] src,
  output logic [W-1:0] en,
  output logic [W-1:0] pend
);
  always_ff @(posedge clk) begin
    if (rst) en <= '0;
    else if (set_we) en <= en | wbits;
    else if (clr_we) en <= en & ~wbits;
  end

  assign pend = src & en;

  p_set_bits_r2: assert property (@(posedge clk) disable iff (rst)
    set_we |=> ((en & $past(wbits)) == $past(wbits)));
  p_clr_bits_r2: assert property (@(posedge clk) disable iff (rst)
    (clr_we && !set_we) |=> ((en & $past(wbits)) == '0));
  p_hold_en_r2: assert property (@(posedge clk) disable iff (rst)
    (!set_we && !clr_we) |=> $stable(en));
endmodule

// File: rtl/irq_base_word.sv
module irq_base_word
  import irq_pkg::*;
(
  input  logic [B0_W-1:0]   pend0,
  input  logic [BK_W-1:0]   pend1,
  input  logic [BK_W-1:0]   pend2,
  output logic [BASE_W-1:0] base
);
  localparam logic [BK_W-1:0] M1 = sc1_mask();
  localparam logic [BK_W-1:0] M2 = sc2_mask();

  assign base[B0_W-1:0] = pend0;
  assign base[SUM1_B]   = |(pend1 & ~M1);
  assign base[SUM2_B]   = |(pend2 & ~M2);

  for (genvar i = 0; i < N_SC1; i++) begin : g_sc1
    assign base[SC_BASE+i] = pend1[sc1_src(i)];
  end
  for (genvar j = 0; j < N_SC2; j++) begin : g_sc2
    assign base[SC_BASE+N_SC1+j] = pend2[sc2_src(j)];
  end
endmodule

// File: rtl/irq_fiq_route.sv
module irq_fiq_route
  import irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             ctl_we,
  input  logic [7:0]       ctl_wdata,
  input  logic [RAW_N-1:0] raw,
  output logic [7:0]       ctl,
  output logic             fiq_o
);
  localparam int PAD_N = 1 << IDX_W;
  logic [PAD_N-1:0] padded;
  logic             sel;

  assign padded = {{(PAD_N-RAW_N){1'b0}}, raw};
  assign sel    = padded[ctl[IDX_W-1:0]];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl   <= '0;
      fiq_o <= 1'b0;
    end else begin
      if (ctl_we) ctl <= ctl_wdata;
      fiq_o <= ctl[7] & sel;
    end
  end

  p_ctl_load_r9: assert property (@(posedge clk) disable iff (rst)
    ctl_we |=> (ctl == $past(ctl_wdata)));
  p_fiq_off_r10: assert property (@(posedge clk) disable iff (rst)
    !ctl[7] |=> !fiq_o);
  p_fiq_hi_idx_r10: assert property (@(posedge clk) disable iff (rst)
    (ctl[IDX_W-1:0] >= IDX_W'(RAW_N)) |=> !fiq_o);
endmodule

// File: rtl/banked_irq_ctrl.sv
module banked_irq_ctrl
  import irq_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [B0_W-1:0]   src_b0,
  input  logic [BK_W-1:0]   src_b1,
  input  logic [BK_W-1:0]   src_b2,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_o,
  output logic              fiq_o
);
  localparam int IDXW = ADDR_W - 2;

  logic [IDXW-1:0]   widx;
  logic              aligned;
  logic [B0_W-1:0]   en0, pend0;
  logic [BK_W-1:0]   en1, en2, pend1, pend2;
  logic [BASE_W-1:0] base;
  logic [7:0]        fctl;
  logic [DATA_W-1:0] rd_next;

  assign widx    = bus_addr[ADDR_W-1:2];
  assign aligned = (bus_addr[1:0] == 2'b00);

  function automatic logic hit(input logic [IDXW-1:0] w, input int k, input logic ok);
    return ok && (w == IDXW'(k));
  endfunction

  irq_en_bank #(.W(B0_W)) u_bank0 (
    .clk(clk), .rst(rst),
    .set_we(bus_we && hit(widx, W_SET0, aligned)),
    .clr_we(bus_we && hit(widx, W_CLR0, aligned)),
    .wbits(bus_wdata[B0_W-1:0]), .src(src_b0), .en(en0), .pend(pend0));

  irq_en_bank #(.W(BK_W)) u_bank1 (
    .clk(clk), .rst(rst),
    .set_we(bus_we && hit(widx, W_SET1, aligned)),
    .clr_we(bus_we && hit(widx, W_CLR1, aligned)),
    .wbits(bus_wdata[BK_W-1:0]), .src(src_b1), .en(en1), .pend(pend1));

  irq_en_bank #(.W(BK_W)) u_bank2 (
    .clk(clk), .rst(rst),
    .set_we(bus_we && hit(widx, W_SET2, aligned)),
    .clr_we(bus_we && hit(widx, W_CLR2, aligned)),
    .wbits(bus_wdata[BK_W-1:0]), .src(src_b2), .en(en2), .pend(pend2));

  irq_base_word u_base (.pend0(pend0), .pend1(pend1), .pend2(pend2), .base(base));

  irq_fiq_route u_fiq (
    .clk(clk), .rst(rst),
    .ctl_we(bus_we && hit(widx, W_FIQ, aligned)),
    .ctl_wdata(bus_wdata[7:0]),
    .raw({src_b0, src_b2, src_b1}),
    .ctl(fctl), .fiq_o(fiq_o));

  always_comb begin
    rd_next = '0;
    if (aligned) begin
      if      (widx == IDXW'(W_PEND0)) rd_next = DATA_W'(base);
      else if (widx == IDXW'(W_PEND1)) rd_next = DATA_W'(pend1);
      else if (widx == IDXW'(W_PEND2)) rd_next = DATA_W'(pend2);
      else if (widx == IDXW'(W_FIQ))   rd_next = DATA_W'(fctl);
      else if (widx == IDXW'(W_SET1) || widx == IDXW'(W_CLR1)) rd_next = DATA_W'(en1);
      else if (widx == IDXW'(W_SET2) || widx == IDXW'(W_CLR2)) rd_next = DATA_W'(en2);
      else if (widx == IDXW'(W_SET0) || widx == IDXW'(W_CLR0)) rd_next = DATA_W'(en0);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      irq_o     <= 1'b0;
    end else begin
      bus_rdata <= rd_next;
      irq_o     <= |base;
    end
  end

  p_irq_rise_r8: assert property (@(posedge clk) disable iff (rst)
    (|base) |=> irq_o);
  p_irq_fall_r8: assert property (@(posedge clk) disable iff (rst)
    !(|base) |=> !irq_o);
  p_fiq_rd_hi_r9: assert property (@(posedge clk) disable iff (rst)
    (aligned && widx == IDXW'(W_FIQ)) |=> (bus_rdata[DATA_W-1:8] == '0));
  p_misaligned_r3: assert property (@(posedge clk) disable iff (rst)
    !aligned |=> (bus_rdata == '0));
  p_b0_hi_zero_r7: assert property (@(posedge clk) disable iff (rst)
    (aligned && (widx == IDXW'(W_SET0) || widx == IDXW'(W_PEND0)))
      |=> (bus_rdata[DATA_W-1:BASE_W] == '0));
endmodule

// File: tb/tb_banked_irq_ctrl.sv
`timescale 1ns/1ps
module tb_banked_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  src_b0 = '0;
  logic [31:0] src_b1 = '0, src_b2 = '0;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_o, fiq_o;

  int total = 0, bad = 0, cyc = 0;
  bit started = 0;

  always #2.5 clk = ~clk;

  banked_irq_ctrl dut (.clk(clk), .rst(rst), .src_b0(src_b0), .src_b1(src_b1),
    .src_b2(src_b2), .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_o(irq_o), .fiq_o(fiq_o));

  // behavioural reference state
  logic [7:0]  m_e0;
  logic [31:0] m_e1, m_e2;
  logic [7:0]  m_fc;
  logic [31:0] x_rd;
  logic        x_irq, x_fiq;
  string       x_tag;
  int sc1 [5] = '{7, 9, 10, 18, 19};
  int sc2 [6] = '{21, 22, 23, 24, 25, 30};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] m_base();
    logic [31:0] b, p1, p2;
    bit ns1, ns2;
    p1 = src_b1 & m_e1;
    p2 = src_b2 & m_e2;
    b = {24'h0, src_b0 & m_e0};
    ns1 = 0; ns2 = 0;
    for (int i = 0; i < 32; i++) begin
      bit is1, is2;
      is1 = 0; is2 = 0;
      foreach (sc1[k]) if (sc1[k] == i) is1 = 1;
      foreach (sc2[k]) if (sc2[k] == i) is2 = 1;
      if (p1[i] && !is1) ns1 = 1;
      if (p2[i] && !is2) ns2 = 1;
    end
    b[8] = ns1;
    b[9] = ns2;
    foreach (sc1[k]) b[10+k] = p1[sc1[k]];
    foreach (sc2[k]) b[15+k] = p2[sc2[k]];
    return b;
  endfunction

  function automatic logic m_raw(input int idx);
    if (idx < 32) return src_b1[idx];
    if (idx < 64) return src_b2[idx-32];
    if (idx < 72) return src_b0[idx-64];
    return 1'b0;
  endfunction

  always @(posedge clk) begin
    cyc++;
    started = 1;
    if (rst) begin
      m_e0 = '0; m_e1 = '0; m_e2 = '0; m_fc = '0;
      x_rd = '0; x_irq = 0; x_fiq = 0; x_tag = "R1";
    end else begin
      logic [31:0] b;
      b = m_base();
      x_irq = |b;
      x_fiq = m_fc[7] && m_raw(int'(m_fc[6:0]));
      x_rd = '0;
      x_tag = "R3";
      if (bus_addr[1:0] == 2'b00) begin
        case (bus_addr)
          8'h00: begin x_rd = b; x_tag = "R6"; end
          8'h04: x_rd = src_b1 & m_e1;
          8'h08: x_rd = src_b2 & m_e2;
          8'h0C: begin x_rd = {24'h0, m_fc}; x_tag = "R9"; end
          8'h10, 8'h1C: begin x_rd = m_e1; x_tag = "R2"; end
          8'h14, 8'h20: begin x_rd = m_e2; x_tag = "R2"; end
          8'h18, 8'h24: begin x_rd = {24'h0, m_e0}; x_tag = "R7"; end
          default: x_rd = '0;
        endcase
        if (bus_we) begin
          case (bus_addr)
            8'h0C: m_fc = bus_wdata[7:0];
            8'h10: m_e1 = m_e1 | bus_wdata;
            8'h14: m_e2 = m_e2 | bus_wdata;
            8'h18: m_e0 = m_e0 | bus_wdata[7:0];
            8'h1C: m_e1 = m_e1 & ~bus_wdata;
            8'h20: m_e2 = m_e2 & ~bus_wdata;
            8'h24: m_e0 = m_e0 & ~bus_wdata[7:0];
            default: ;
          endcase
        end
      end
    end
    if (cyc > 150000) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (started) begin
      chk({x_tag, " rdata model"}, bus_rdata, x_rd);
      chk("R8 irq model", {31'h0, irq_o}, {31'h0, x_irq});
      chk("R10 fiq model", {31'h0, fiq_o}, {31'h0, x_fiq});
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(posedge clk); #1;
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    @(posedge clk); #1;
    bus_addr = a; bus_we = 1'b0;
    @(posedge clk);
    @(negedge clk);
    v = bus_rdata;
  endtask

  task automatic settle();
    @(posedge clk); @(posedge clk); @(negedge clk);
  endtask

  initial begin
    logic [31:0] v;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    chk("R1 irq after reset", {31'h0, irq_o}, 32'h0);
    chk("R1 fiq after reset", {31'h0, fiq_o}, 32'h0);
    chk("R1 rdata after reset", bus_rdata, 32'h0);
    rd(8'h10, v); chk("R1 bank1 enable zero", v, 32'h0);
    rd(8'h0C, v); chk("R1 fiq control zero", v, 32'h0);

    // R2 set / clear semantics
    wr(8'h10, 32'h0000_0081);
    rd(8'h1C, v); chk("R2 set via 0x10 read at 0x1C", v, 32'h81);
    wr(8'h10, 32'h0);
    rd(8'h10, v); chk("R2 zero write leaves mask", v, 32'h81);
    wr(8'h1C, 32'h1);
    rd(8'h10, v); chk("R2 clear bit0", v, 32'h80);

    // R3 pending masking, pending writes ignored, misaligned
    #1 src_b1 = 32'hFFFF_FFFF;
    rd(8'h04, v); chk("R3 bank1 pending masked", v, 32'h80);
    wr(8'h04, 32'h0);
    rd(8'h04, v); chk("R3 pending write ignored", v, 32'h80);
    rd(8'h05, v); chk("R3 misaligned reads zero", v, 32'h0);
    wr(8'h11, 32'hFFFF_FFFF);
    rd(8'h10, v); chk("R3 misaligned write ignored", v, 32'h80);

    // R6 shortcut without summary, R5 summary
    rd(8'h00, v); chk("R6 shortcut src7 -> bit10, no bit8", v, 32'h400);
    wr(8'h10, 32'h1);
    rd(8'h00, v); chk("R5 summary bit8 from src0", v, 32'h500);
    #1 src_b2 = 32'hFFFF_FFFF;
    wr(8'h14, 32'h4000_0000);
    rd(8'h00, v); chk("R6 bank2 src30 -> bit20 only", v, 32'h10_0500);
    wr(8'h14, 32'h8);
    rd(8'h00, v); chk("R5 summary bit9", v, 32'h10_0700);
    rd(8'h08, v); chk("R6 shortcut still in bank pending", v, 32'h4000_0008);

    // R4 / R7 bank 0
    #1 src_b0 = 8'hA5;
    wr(8'h18, 32'hFFFF_FF0F);
    rd(8'h18, v); chk("R7 bank0 enable upper bits ignored", v, 32'h0F);
    rd(8'h00, v); chk("R4 base low byte", v, 32'h10_0705);
    wr(8'h24, 32'hFFFF_FF00);
    rd(8'h24, v); chk("R7 bank0 clear upper bits ignored", v, 32'h0F);

    // R8 irq follows base word
    wr(8'h1C, 32'hFFFF_FFFF);
    wr(8'h20, 32'hFFFF_FFFF);
    wr(8'h24, 32'hFF);
    settle();
    chk("R8 irq low with all masked", {31'h0, irq_o}, 32'h0);
    wr(8'h14, 32'h0200_0000);
    settle();
    chk("R8 irq from shortcut src25", {31'h0, irq_o}, 32'h1);
    wr(8'h20, 32'h0200_0000);

    // R9 / R10 fiq routing
    wr(8'h0C, 32'hFFFF_FF85);
    rd(8'h0C, v); chk("R9 fiq control readback", v, 32'h85);
    settle();
    chk("R10 fiq without irq enable", {31'h0, fiq_o}, 32'h1);
    chk("R10 irq stays low", {31'h0, irq_o}, 32'h0);
    #1 src_b0 = 8'h04;
    wr(8'h0C, 32'h0000_00C2);
    settle();
    chk("R9 index 66 selects bank0 src2", {31'h0, fiq_o}, 32'h1);
    wr(8'h0C, 32'h0000_00E4);
    settle();
    chk("R10 index 100 selects nothing", {31'h0, fiq_o}, 32'h0);
    wr(8'h0C, 32'h0000_0085);
    wr(8'h10, 32'h20);
    settle();
    chk("R10 both outputs together fiq", {31'h0, fiq_o}, 32'h1);
    chk("R10 both outputs together irq", {31'h0, irq_o}, 32'h1);
    wr(8'h0C, 32'h0000_0005);
    settle();
    chk("R10 fiq disabled", {31'h0, fiq_o}, 32'h0);

    // random phase, checked by the per-cycle model
    for (int n = 0; n < 3000; n++) begin
      logic [7:0] offs [11];
      offs = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h10, 8'h14, 8'h18, 8'h1C, 8'h20, 8'h24, 8'h2A};
      @(posedge clk); #1;
      src_b0 = 8'($urandom);
      src_b1 = $urandom & $urandom;
      src_b2 = $urandom & $urandom;
      bus_addr = offs[$urandom_range(10)];
      bus_we = ($urandom_range(3) == 0);
      bus_wdata = $urandom;
    end
    @(posedge clk); #1 bus_we = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule